// File: doc/BRIEF.md
# Indexed-Window Interrupt Redirection Controller

This block routes a set of interrupt input pins to a single delivery request channel. Each pin has its own 64-bit routing entry. The entry selects edge or level capture and the active polarity, can mask the pin, and supplies the vector, delivery mode and destination that travel with the request. A level-triggered pin keeps a remote in-service flag. The flag is set when its request is accepted and cleared by an end-of-interrupt notice that carries the same vector. While the flag is set, the pin raises no further request.

Software reaches every register through two bus offsets. A write to offset 0x00 selects a register index. Reads and writes at offset 0x10 then act on the selected register. The index stays in place after an access, so a read-modify-write needs only one index write. Reads have no side effects, so a dummy read can be used to flush earlier posted writes. Requests leave through a valid/ready pair. Only one request is in flight at a time, and the lowest-numbered pending pin wins.

Top module: `irq_router`

## Requirements
- R1: A bus write at offset 0x00 latches wdata[7:0] as the index, and offset 0x00 reads the index back in bits 7:0. Window accesses at offset 0x10 act on the last index written, and the index persists across any number of window accesses. Any other offset reads zero and ignores writes.
- R2: A read has no side effect. Reading an entry twice returns the same word, and pending status is left unchanged.
- R3: Index 0x00 holds a writable 4-bit ID in bits 27:24 (reset value ID_RESET, default 0). Index 0x02 returns the same ID in bits 27:24 and ignores writes. All other bits of both read as zero.
- R4: Index 0x01 is read-only. It holds VERSION (default 0x11) in bits 7:0, the PRQ flag (default 1) in bit 15, and NUM_PINS-1 in bits 23:16. With the defaults it reads 0x00178011.
- R5: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. Low word layout:
  - bits 7:0: vector
  - bits 10:8: delivery mode
  - bit 11: destination mode (1 = logical)
  - bit 12: delivery status
  - bit 13: polarity (1 = active low)
  - bit 14: remote in-service flag
  - bit 15: trigger (1 = level)
  - bit 16: mask (1 = disabled)
  
  The high word holds the destination in bits 31:24. After reset the low word reads 0x00010000 and the high word reads 0. Indexes 0x03 to 0x0F and indexes from 0x10+2*NUM_PINS upward read zero and ignore writes.
- R6: Bits 12 and 14 of a low word ignore writes, as do all reserved bits. A written low word reads back ANDed with 0x0001AFFF, and a written high word reads back ANDed with 0xFF000000.
- R7: An edge-triggered, unmasked pin posts one request for each transition into its active level. req_valid rises two clock edges after the input changes. A pin that stays active posts nothing more, and an edge seen while the pin is masked is dropped.
- R8: A level-triggered pin posts a request while it is active, unmasked and its in-service flag is clear. Acceptance sets the flag. An end-of-interrupt pulse whose vector matches clears it, and a pulse with any other vector does not. A pin that is still active posts again two edges after the clearing pulse.
- R9: Delivery status reads 1 from the edge on which a request becomes pending until the edge that accepts it.
- R10: The request carries the entry's vector, mode, destination mode, trigger and pin number. The destination is bits 31:24 in logical mode and the zero-extended bits 27:24 in physical mode. All of these stay stable while req_valid is high and req_ready is low.
- R11: The lowest-numbered pending pin is issued first. After an acceptance req_valid is low for one cycle, and the next pending pin is presented on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_pins | input | NUM_PINS | Synchronous interrupt inputs |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Request accepted on this edge when valid |
| req_vector | output | 8 | Request vector |
| req_mode | output | 3 | Delivery mode (0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT, 7 external) |
| req_dest_logical | output | 1 | Destination mode, 1 = logical |
| req_dest | output | 8 | Destination |
| req_level | output | 1 | Request came from a level-triggered pin |
| req_pin | output | PIN_W | Source pin number |

## Verification
Register reads are combinational, so the bench samples bus_rdata a fraction of a cycle after it sets the address, while an index write takes effect at the next edge. A pin change driven at a falling edge registers as pending on the next rising edge, and req_valid appears on the rising edge after that. The bench therefore checks that req_valid is still low one cycle after the change and high after the second. An acceptance clears req_valid and the pending status on the same edge. The next pin appears one edge later, and a cleared in-service flag lets a level pin post two edges after the end-of-interrupt.

// File: rtl/irq_router_pkg.sv
// Package: shared types and fixed index/offset constants for the
// interrupt redirection controller.
package irq_router_pkg;

    // Bus byte offsets of the two visible registers.
    localparam logic [7:0] OFS_INDEX  = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    // Register indexes reached through the window.
    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam logic [7:0] IDX_TABLE = 8'h10;

    // Software-programmed part of one routing entry.
    typedef struct packed {
        logic       mask;
        logic       trig_level;
        logic       active_low;
        logic       dest_logical;
        logic [2:0] mode;
        logic [7:0] vector;
        logic [7:0] dest;
    } route_cfg_t;

    // Payload carried by one delivery request.
    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       dest_logical;
        logic [7:0] dest;
        logic       trig_level;
    } deliv_t;

    // Assemble the low word of an entry with its live status bits.
    function automatic logic [31:0] low_word(route_cfg_t c, logic dstat, logic rirr);
        return {15'h0, c.mask, c.trig_level, rirr, c.active_low, dstat,
                c.dest_logical, c.mode, c.vector};
    endfunction

endpackage

// File: rtl/irq_reg_window.sv
// Module: irq_reg_window
// Holds the index register, the ID register and the routing-entry table,
// and serves the index/data window. Assumes single-cycle bus strobes;
// reads are combinational and change no state.
module irq_reg_window
    import irq_router_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [3:0] ID_RESET = 4'h0,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic       PRQ      = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [7:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_PINS-1:0]          dstat,
    input  logic [NUM_PINS-1:0]          rirr,
    output route_cfg_t [NUM_PINS-1:0]    cfg,
    output logic [7:0]                   index_o
);
    localparam int TABLE_END = 16 + 2 * NUM_PINS;

    logic [7:0]  index_q;
    logic [3:0]  id_q;
    logic        win_wr;
    logic        in_table;
    logic [7:0]  tbl_off;
    logic [6:0]  sel_entry;
    logic        hi_sel;
    route_cfg_t  rd_cfg;
    logic        rd_dstat;
    logic        rd_rirr;
    logic [31:0] win_data;

    assign win_wr    = bus_en && bus_we && (bus_addr == OFS_WINDOW);
    assign in_table  = (index_q >= IDX_TABLE) && (32'(index_q) < TABLE_END);
    assign tbl_off   = index_q - IDX_TABLE;
    assign sel_entry = tbl_off[7:1];
    assign hi_sel    = tbl_off[0];
    assign index_o   = index_q;

    // Index register: latched by a write at the index offset only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (bus_en && bus_we && (bus_addr == OFS_INDEX))
            index_q <= bus_wdata[7:0];
    end

    // ID register: only bits 27:24 of a window write to index 0 land.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= ID_RESET;
        else if (win_wr && (index_q == IDX_ID))
            id_q <= bus_wdata[27:24];
    end

    // Routing entries: one register set per pin, low or high word written.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g]      <= '0;
                cfg[g].mask <= 1'b1;
            end else if (win_wr && in_table && (sel_entry == 7'(g))) begin
                if (hi_sel) begin
                    cfg[g].dest <= bus_wdata[31:24];
                end else begin
                    cfg[g].vector       <= bus_wdata[7:0];
                    cfg[g].mode         <= bus_wdata[10:8];
                    cfg[g].dest_logical <= bus_wdata[11];
                    cfg[g].active_low   <= bus_wdata[13];
                    cfg[g].trig_level   <= bus_wdata[15];
                    cfg[g].mask         <= bus_wdata[16];
                end
            end
        end
    end

    // Entry read select: pick the addressed entry and its status bits.
    always_comb begin
        rd_cfg   = '0;
        rd_dstat = 1'b0;
        rd_rirr  = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_entry == 7'(i)) begin
                rd_cfg   = cfg[i];
                rd_dstat = dstat[i];
                rd_rirr  = rirr[i];
            end
        end
    end

    // Window data: decode of the current index into a 32-bit word.
    always_comb begin
        win_data = '0;
        if (index_q == IDX_ID)
            win_data[27:24] = id_q;
        else if (index_q == IDX_VER)
            win_data = {8'h00, 8'(NUM_PINS - 1), PRQ, 7'h00, VERSION};
        else if (index_q == IDX_ARB)
            win_data[27:24] = id_q;
        else if (in_table)
            win_data = hi_sel ? {rd_cfg.dest, 24'h0}
                              : low_word(rd_cfg, rd_dstat, rd_rirr);
    end

    // Read port: index or window data on a read strobe, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == OFS_INDEX)
                bus_rdata = {24'h0, index_q};
            else if (bus_addr == OFS_WINDOW)
                bus_rdata = win_data;
        end
    end

endmodule

// File: rtl/irq_pin_tracker.sv
// Module: irq_pin_tracker
// Capture logic for one interrupt pin: polarity, edge detection, level
// sampling, pending (delivery status) and the remote in-service flag.
// Assumes pin_in is already synchronous to clk. While the pin's request
// is granted or in flight, its pending state is frozen.
module irq_pin_tracker
    import irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  route_cfg_t cfg,
    input  logic       hold,
    input  logic       accept,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       pending_o,
    output logic       rirr_o
);
    logic asserted;
    logic prev_q;
    logic rise;
    logic pending_q;
    logic rirr_q;

    assign asserted  = pin_in ^ cfg.active_low;
    assign rise      = asserted && !prev_q;
    assign pending_o = pending_q;
    assign rirr_o    = rirr_q;

    // Previous active level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= asserted;
    end

    // Pending: set by capture, frozen while issued, cleared on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (accept)
            pending_q <= 1'b0;
        else if (hold)
            pending_q <= pending_q;
        else if (cfg.trig_level)
            pending_q <= asserted && !cfg.mask && !rirr_q;
        else
            pending_q <= (pending_q || rise) && !cfg.mask;
    end

    // Remote in-service: set on level accept, cleared by matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rirr_q <= 1'b0;
        else if (accept && cfg.trig_level)
            rirr_q <= 1'b1;
        else if (!cfg.trig_level)
            rirr_q <= 1'b0;
        else if (eoi_valid && (eoi_vector == cfg.vector))
            rirr_q <= 1'b0;
    end

endmodule

// File: rtl/irq_deliver_stage.sv
// Module: irq_deliver_stage
// Picks the lowest-numbered pending pin, registers its payload and holds
// it on a valid/ready output until accepted. One request in flight.
module irq_deliver_stage
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pending,
    input  route_cfg_t [NUM_PINS-1:0] cfg,
    input  logic                      req_ready,
    output logic                      req_valid,
    output logic [PIN_W-1:0]          req_pin,
    output deliv_t                    req_data,
    output logic [NUM_PINS-1:0]       hold,
    output logic [NUM_PINS-1:0]       accept
);
    logic             valid_q;
    logic [PIN_W-1:0] pin_q;
    deliv_t           data_q;
    logic             any;
    logic             load;
    logic [PIN_W-1:0] pick;
    route_cfg_t       pick_cfg;
    deliv_t           pick_data;

    assign any       = |pending;
    assign load      = !valid_q && any;
    assign req_valid = valid_q;
    assign req_pin   = pin_q;
    assign req_data  = data_q;

    // Priority pick: lowest index wins, so scan downward.
    always_comb begin
        pick     = '0;
        pick_cfg = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick     = PIN_W'(i);
                pick_cfg = cfg[i];
            end
        end
    end

    // Payload build: physical mode keeps the low nibble of the destination.
    always_comb begin
        pick_data.vector       = pick_cfg.vector;
        pick_data.mode         = pick_cfg.mode;
        pick_data.dest_logical = pick_cfg.dest_logical;
        pick_data.dest         = pick_cfg.dest_logical ? pick_cfg.dest
                                                       : {4'h0, pick_cfg.dest[3:0]};
        pick_data.trig_level   = pick_cfg.trig_level;
    end

    // Per-pin grant/in-flight and accept strobes.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_strobe
        assign hold[g]   = (valid_q && (pin_q == PIN_W'(g))) || (load && (pick == PIN_W'(g)));
        assign accept[g] = valid_q && req_ready && (pin_q == PIN_W'(g));
    end

    // Output register: load when idle, drop on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pin_q   <= '0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            pin_q   <= pick;
            data_q  <= pick_data;
        end else if (valid_q && req_ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Interrupt redirection controller: index/data register window, per-pin
// routing entries and capture, single valid/ready delivery channel.
// Assumes irq_pins and bus signals are synchronous to clk.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [3:0] ID_RESET = 4'h0,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic       PRQ      = 1'b1,
    localparam int        PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pins,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [7:0]          req_vector,
    output logic [2:0]          req_mode,
    output logic                req_dest_logical,
    output logic [7:0]          req_dest,
    output logic                req_level,
    output logic [PIN_W-1:0]    req_pin
);
    route_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]       dstat;
    logic [NUM_PINS-1:0]       rirr;
    logic [NUM_PINS-1:0]       hold;
    logic [NUM_PINS-1:0]       accept;
    logic [7:0]                win_index;
    deliv_t                    req_data;

    irq_reg_window #(
        .NUM_PINS (NUM_PINS),
        .ID_RESET (ID_RESET),
        .VERSION  (VERSION),
        .PRQ      (PRQ)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dstat     (dstat),
        .rirr      (rirr),
        .cfg       (cfg),
        .index_o   (win_index)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irq_pin_tracker u_tracker (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_in     (irq_pins[g]),
            .cfg        (cfg[g]),
            .hold       (hold[g]),
            .accept     (accept[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .pending_o  (dstat[g]),
            .rirr_o     (rirr[g])
        );
    end

    irq_deliver_stage #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_deliver (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (dstat),
        .cfg       (cfg),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_pin   (req_pin),
        .req_data  (req_data),
        .hold      (hold),
        .accept    (accept)
    );

    assign req_vector       = req_data.vector;
    assign req_mode         = req_data.mode;
    assign req_dest_logical = req_data.dest_logical;
    assign req_dest         = req_data.dest;
    assign req_level        = req_data.trig_level;

endmodule

// File: rtl/irq_router_checker.sv
// Module: irq_router_checker
// Concurrent properties over the ports and status vectors of irq_router,
// bound into every instance of it.
module irq_router_checker #(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic       PRQ      = 1'b1,
    localparam int        PIN_W    = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic                req_valid,
    input logic                req_ready,
    input logic [7:0]          req_vector,
    input logic [2:0]          req_mode,
    input logic                req_dest_logical,
    input logic [7:0]          req_dest,
    input logic                req_level,
    input logic [PIN_W-1:0]    req_pin,
    input logic [7:0]          win_index,
    input logic [NUM_PINS-1:0] dstat,
    input logic [NUM_PINS-1:0] rirr
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid &&
        $stable({req_vector, req_mode, req_dest_logical, req_dest, req_level, req_pin})); // R10

    AST_ACCEPT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R11

    AST_STATUS_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> dstat[req_pin]); // R9

    AST_NO_POST_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> !rirr[req_pin]); // R8

    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && (bus_addr == 8'h10) && (win_index == 8'h01) |->
        bus_rdata == {8'h00, 8'(NUM_PINS - 1), PRQ, 7'h00, VERSION}); // R4

    AST_READ_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we |=> $stable(win_index)); // R2

endmodule

bind irq_router irq_router_checker #(
    .NUM_PINS (NUM_PINS),
    .VERSION  (VERSION),
    .PRQ      (PRQ)
) u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_en           (bus_en),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_rdata        (bus_rdata),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_vector       (req_vector),
    .req_mode         (req_mode),
    .req_dest_logical (req_dest_logical),
    .req_dest         (req_dest),
    .req_level        (req_level),
    .req_pin          (req_pin),
    .win_index        (win_index),
    .dstat            (dstat),
    .rirr             (rirr)
);

// File: tb/test_irq_router.sv
// Bench: sweeps the register space and every pin of irq_router with
// expected values computed from the requirements.
module test_irq_router;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_pins = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          req_valid, req_ready = 1'b0;
    logic [7:0]    req_vector, req_dest;
    logic [2:0]    req_mode;
    logic          req_dest_logical, req_level;
    logic [4:0]    req_pin;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pins(irq_pins), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
        .req_mode(req_mode), .req_dest_logical(req_dest_logical),
        .req_dest(req_dest), .req_level(req_level), .req_pin(req_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic accept_one();
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] reset_word(input int idx);
        if (idx == 1) return {8'h00, 8'(NP - 1), 1'b1, 7'h00, 8'h11};
        if (idx >= 16 && idx < 16 + 2 * NP && (idx % 2) == 0) return 32'h0001_0000;
        return 32'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2, wl, wh;
        logic [4:0]  first_pin;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state of the whole index space and the outputs.
        chk("R11 reset req_valid", {31'h0, req_valid}, 32'h0);
        bus_read(8'h00, d);
        chk("R1 reset index", d, 32'h0);
        for (int i = 0; i < 80; i++) begin
            reg_read(8'(i), d);
            chk($sformatf("R5 reset word idx %0d", i), d, reset_word(i));
        end

        // ID, arbitration and version registers.
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, d);
        chk("R3 id write", d, 32'h0F00_0000);
        reg_read(8'h02, d);
        chk("R3 arb mirrors id", d, 32'h0F00_0000);
        reg_write(8'h02, 32'h0000_0000);
        reg_read(8'h02, d);
        chk("R3 arb ignores write", d, 32'h0F00_0000);
        reg_write(8'h01, 32'h0);
        reg_read(8'h01, d);
        chk("R4 version read-only", d, 32'h0017_8011);

        // Entry write/readback sweep with masked patterns.
        for (int n = 0; n < NP; n++) begin
            wl = (32'(n) * 32'h9E37_79B1) | 32'h0001_0000;
            wh = 32'(n + 1) * 32'h85EB_CA6B;
            reg_write(8'(16 + 2 * n), wl);
            reg_write(8'(17 + 2 * n), wh);
        end
        for (int n = 0; n < NP; n++) begin
            wl = (32'(n) * 32'h9E37_79B1) | 32'h0001_0000;
            wh = 32'(n + 1) * 32'h85EB_CA6B;
            reg_read(8'(16 + 2 * n), d);
            chk($sformatf("R6 low readback pin %0d", n), d, wl & 32'h0001_AFFF);
            reg_read(8'(17 + 2 * n), d);
            chk($sformatf("R5 high readback pin %0d", n), d, wh & 32'hFF00_0000);
        end

        // Index persists: window-only write after a read hits the same entry.
        reg_read(8'h14, d);
        bus_write(8'h10, 32'h0001_8A5C);
        bus_read(8'h10, d);
        chk("R1 index persists write", d, 32'h0001_8A5C);
        bus_read(8'h00, d);
        chk("R1 index readback", d, 32'h0000_0014);
        bus_write(8'h04, 32'h0000_0033);
        bus_read(8'h00, d);
        chk("R1 other offset ignored", d, 32'h0000_0014);
        bus_read(8'h08, d);
        chk("R1 other offset reads zero", d, 32'h0);

        // Out-of-range indexes ignore writes.
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_write(8'h03, 32'hFFFF_FFFF);
        reg_read(8'h40, d);
        chk("R5 idx 0x40 zero", d, 32'h0);
        reg_read(8'h03, d);
        chk("R5 idx 0x03 zero", d, 32'h0);
        reg_read(8'h3F, d);
        chk("R5 last entry intact", d, (32'(NP) * 32'h85EB_CA6B) & 32'hFF00_0000);

        // Program all pins: edge, active high, unmasked, vector 0x20+n.
        for (int n = 0; n < NP; n++) begin
            reg_write(8'(17 + 2 * n), 32'h0);
            reg_write(8'(16 + 2 * n), 32'(8'h20 + 8'(n)));
        end
        repeat (2) tick();
        chk("R7 no spurious request", {31'h0, req_valid}, 32'h0);

        // Edge sweep over every pin.
        for (int n = 0; n < NP; n++) begin
            irq_pins[n] = 1'b1;
            tick();
            chk($sformatf("R7 edge pin %0d not yet", n), {31'h0, req_valid}, 32'h0);
            tick();
            chk($sformatf("R7 edge pin %0d valid", n), {31'h0, req_valid}, 32'h1);
            chk($sformatf("R10 pin %0d number", n), {27'h0, req_pin}, 32'(n));
            chk($sformatf("R10 pin %0d vector", n), {24'h0, req_vector}, 32'(8'h20 + 8'(n)));
            reg_read(8'(16 + 2 * n), d);
            bus_read(8'h10, d2);
            chk($sformatf("R9 pin %0d status set", n), d, 32'h0000_1000 | 32'(8'h20 + 8'(n)));
            chk($sformatf("R2 pin %0d reread", n), d2, d);
            accept_one();
            chk($sformatf("R11 pin %0d drop", n), {31'h0, req_valid}, 32'h0);
            bus_read(8'h10, d);
            chk($sformatf("R9 pin %0d status clear", n), d, 32'(8'h20 + 8'(n)));
            repeat (3) tick();
            chk($sformatf("R7 pin %0d held no repeat", n), {31'h0, req_valid}, 32'h0);
            irq_pins[n] = 1'b0;
            tick();
        end

        // Polarity: active-low pin 5.
        reg_write(8'h1A, 32'h0001_2025);
        tick();
        reg_write(8'h1A, 32'h0000_2025);
        repeat (3) tick();
        chk("R7 active-low idle", {31'h0, req_valid}, 32'h0);
        irq_pins[5] = 1'b1;
        repeat (3) tick();
        chk("R7 active-low deassert", {31'h0, req_valid}, 32'h0);
        irq_pins[5] = 1'b0;
        repeat (2) tick();
        chk("R7 active-low edge", {26'h0, req_valid, req_pin}, {26'h0, 1'b1, 5'd5});
        accept_one();
        reg_write(8'h1A, 32'h0001_2025);

        // Mask: edge on masked pin 6 is dropped.
        reg_write(8'h1C, 32'h0001_0026);
        irq_pins[6] = 1'b1;
        repeat (4) tick();
        chk("R7 masked edge", {31'h0, req_valid}, 32'h0);
        reg_write(8'h1C, 32'h0000_0026);
        repeat (3) tick();
        chk("R7 masked edge lost", {31'h0, req_valid}, 32'h0);
        irq_pins[6] = 1'b0;
        tick();

        // Arbitration among pins 17, 9, 3, raised together.
        irq_pins[17] = 1'b1; irq_pins[9] = 1'b1; irq_pins[3] = 1'b1;
        repeat (2) tick();
        chk("R11 first pin", {27'h0, req_pin}, 32'd3);
        first_pin = req_pin;
        repeat (3) tick();
        chk("R10 held pin", {27'h0, req_pin}, {27'h0, first_pin});
        chk("R10 held vector", {24'h0, req_vector}, 32'h23);
        accept_one();
        chk("R11 gap cycle", {31'h0, req_valid}, 32'h0);
        tick();
        chk("R11 second pin", {26'h0, req_valid, req_pin}, {26'h0, 1'b1, 5'd9});
        accept_one();
        tick();
        chk("R11 third pin", {26'h0, req_valid, req_pin}, {26'h0, 1'b1, 5'd17});
        accept_one();
        irq_pins[17] = 1'b0; irq_pins[9] = 1'b0; irq_pins[3] = 1'b0;
        tick();

        // Level pin 12: logical dest 0xA5, lowest priority, vector 0x55.
        reg_write(8'h29, 32'hA500_0000);
        reg_write(8'h28, 32'h0000_8955);
        irq_pins[12] = 1'b1;
        repeat (2) tick();
        chk("R8 level valid", {31'h0, req_valid}, 32'h1);
        chk("R10 level payload", {8'h0, req_dest, 2'b0, req_level, req_dest_logical, 1'b0, req_mode, req_vector},
            {8'h0, 8'hA5, 2'b0, 1'b1, 1'b1, 1'b0, 3'd1, 8'h55});
        accept_one();
        reg_read(8'h28, d);
        chk("R8 in-service set", d, 32'h0000_C955);
        repeat (3) tick();
        chk("R8 blocked while in service", {31'h0, req_valid}, 32'h0);
        reg_write(8'h28, 32'h0000_9955);
        reg_read(8'h28, d);
        chk("R6 status bits read-only", d, 32'h0000_C955);
        eoi_valid = 1'b1; eoi_vector = 8'h56;
        tick();
        eoi_valid = 1'b0;
        reg_read(8'h28, d);
        chk("R8 wrong EOI ignored", d, 32'h0000_C955);
        eoi_valid = 1'b1; eoi_vector = 8'h55;
        tick();
        eoi_valid = 1'b0;
        tick();
        chk("R8 repost not yet", {31'h0, req_valid}, 32'h0);
        tick();
        chk("R8 repost after EOI", {26'h0, req_valid, req_pin}, {26'h0, 1'b1, 5'd12});
        accept_one();
        irq_pins[12] = 1'b0;
        eoi_valid = 1'b1;
        tick();
        eoi_valid = 1'b0;
        repeat (4) tick();
        chk("R8 idle after drop", {31'h0, req_valid}, 32'h0);

        // Physical destination on pin 14: high byte 0xB7 gives 0x07, mode SMI.
        reg_write(8'h2D, 32'hB700_0000);
        reg_write(8'h2C, 32'h0000_0240);
        irq_pins[14] = 1'b1;
        repeat (2) tick();
        chk("R10 physical dest", {8'h0, req_dest, 3'b0, req_dest_logical, 1'b0, req_mode, req_vector},
            {8'h0, 8'h07, 3'b0, 1'b0, 1'b0, 3'd2, 8'h40});
        accept_one();
        irq_pins[14] = 1'b0;
        tick();

        finish_run();
    end
endmodule